// File: doc/BRIEF.md
# Multiplexed four-digit display driver

This block drives four common-anode seven-segment digits that share a single segment bus. It shows one digit at a time and switches to the next digit on a slow scan tick. The tick is produced inside the block by dividing the system clock down to 250 Hz. Because the scan repeats quickly, the eye sees all four digits lit at once. The caller supplies three BCD digits for hundreds, tens and units, plus a fourth value for the leftmost position. A mode input picks what that leftmost position shows: either a sign indicator driven by a negative flag, or a fourth BCD digit.

The block has a built-in decimal-to-segment decoder. Codes outside 0 to 9 are shown as a dark digit. After reset every digit stays dark until the first scan tick. From then on the scan starts at the rightmost digit and moves leftwards, wrapping around after the leftmost digit. Segment values follow the data inputs combinationally for whichever digit is currently enabled.

Top module: `mux_display_driver`

## Requirements
- R1: A scan tick occurs once every CLK_HZ/SCAN_HZ clock cycles (a divider limit of 399999 at 100 MHz and 250 Hz). The first tick comes that many cycles after reset is released, and the enabled digit changes only on the cycle after a tick.
- R2: Anodes are active-low (`an_n` bit 0 is the rightmost digit, bit 3 the leftmost). After the first tick, exactly one anode bit is 0 on every cycle.
- R3: Each scan tick moves the enabled digit from bit 0 to bit 1, then bit 2, then bit 3, and then back to bit 0.
- R4: While reset is held and until the first tick after it, `an_n` is 4'b1111 and `seg_n` is 7'b1111111. The first tick enables bit 0.
- R5: Segments are active-low, with `seg_n` bit order {g,f,e,d,c,b,a}. BCD 0..9 produce the active-high patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, and `seg_n` carries their bitwise inverse.
- R6: A BCD code from 10 to 15 on an enabled digit gives `seg_n` = 7'b1111111 (blank).
- R7: With `lead_is_sign`=1, the leftmost digit shows the sign. If `negative`=1 only segment g is lit (`seg_n` = 7'b0111111); if `negative`=0 the digit is blank. `digit_lead` has no effect in this mode.
- R8: With `lead_is_sign`=0, the leftmost digit shows the decoded `digit_lead`, and `negative` has no effect.
- R9: Bit 0 shows `digit_units`, bit 1 shows `digit_tens` and bit 2 shows `digit_hundreds`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_is_sign | input | 1 | 1: leftmost digit shows the sign; 0: leftmost digit shows `digit_lead` |
| negative | input | 1 | Sign flag used when `lead_is_sign` is 1 |
| digit_lead | input | 4 | BCD value for the leftmost digit in digit mode |
| digit_hundreds | input | 4 | BCD hundreds |
| digit_tens | input | 4 | BCD tens |
| digit_units | input | 4 | BCD units |
| an_n | output | 4 | Active-low digit enables, bit 0 rightmost |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |

## Verification
Patterns with a different value in each position (for example 9/1/2/3) show whether each anode is paired with the correct data input. Patterns with the same value in every position exercise the decoder for each code 0..9 in turn, and the codes 10..15 separate blanking from a wrong decode. Sign mode is run with both values of the negative flag, with the leftmost BCD input set to a nonzero value it must ignore. Digit mode is run with the negative flag held high, which shows whether the mode selection is honoured. A reset in the middle of a scan checks that the block returns to the dark state and that the tick spacing starts again from zero.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int NUM_DIGITS = 4;
    localparam int SEG_W      = 7;
    localparam int BCD_W      = 4;
    localparam int IDX_W      = $clog2(NUM_DIGITS);

    typedef logic [BCD_W-1:0]      bcd_t;
    typedef logic [SEG_W-1:0]      seg_t;
    typedef logic [NUM_DIGITS-1:0] anode_t;

    // Scan position; numeric value equals the anode bit it enables.
    typedef enum logic [IDX_W-1:0] {
        SLOT_UNITS    = 2'd0,
        SLOT_TENS     = 2'd1,
        SLOT_HUNDREDS = 2'd2,
        SLOT_LEAD     = 2'd3
    } slot_e;

    typedef struct packed {
        logic lead_is_sign;
        logic negative;
        bcd_t lead;
        bcd_t hundreds;
        bcd_t tens;
        bcd_t units;
    } disp_value_t;

    typedef struct packed {
        logic  active;
        slot_e slot;
    } scan_state_t;

    // Segment order {g,f,e,d,c,b,a}, active-low on the bus.
    localparam seg_t SEG_BLANK = 7'b1111111;
    localparam seg_t SEG_MINUS = 7'b0111111;

    function automatic seg_t bcd_to_seg(input bcd_t v);
        seg_t lit;
        case (v)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
        return ~lit;
    endfunction

    function automatic int unsigned scan_limit(input int unsigned clk_hz,
                                               input int unsigned scan_hz);
        return (clk_hz / scan_hz) - 1;
    endfunction

endpackage

// File: rtl/scan_divider.sv
module scan_divider
    import disp_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned SCAN_HZ = 250
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned LIMIT = scan_limit(CLK_HZ, SCAN_HZ);
    localparam int CNT_W = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/digit_sequencer.sv
module digit_sequencer
    import disp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    output scan_state_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state.active <= 1'b0;
            state.slot   <= SLOT_UNITS;
        end else if (tick) begin
            if (!state.active) begin
                state.active <= 1'b1;
            end else begin
                state.slot <= slot_e'(IDX_W'(state.slot) + IDX_W'(1));
            end
        end
    end
endmodule

// File: rtl/digit_select_decode.sv
module digit_select_decode
    import disp_pkg::*;
(
    input  disp_value_t val,
    input  scan_state_t st,
    output anode_t      an_n,
    output seg_t        seg_n
);
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_anode
        assign an_n[g] = !(st.active && (IDX_W'(st.slot) == IDX_W'(g)));
    end

    seg_t lead_seg;

    always_comb begin
        if (val.lead_is_sign) begin
            lead_seg = val.negative ? SEG_MINUS : SEG_BLANK;
        end else begin
            lead_seg = bcd_to_seg(val.lead);
        end
    end

    always_comb begin
        if (!st.active) begin
            seg_n = SEG_BLANK;
        end else begin
            case (st.slot)
                SLOT_UNITS:    seg_n = bcd_to_seg(val.units);
                SLOT_TENS:     seg_n = bcd_to_seg(val.tens);
                SLOT_HUNDREDS: seg_n = bcd_to_seg(val.hundreds);
                SLOT_LEAD:     seg_n = lead_seg;
                default:       seg_n = SEG_BLANK;
            endcase
        end
    end
endmodule

// File: rtl/mux_display_driver.sv
module mux_display_driver
    import disp_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned SCAN_HZ = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lead_is_sign,
    input  logic       negative,
    input  logic [3:0] digit_lead,
    input  logic [3:0] digit_hundreds,
    input  logic [3:0] digit_tens,
    input  logic [3:0] digit_units,
    output logic [3:0] an_n,
    output logic [6:0] seg_n
);
    logic        scan_tick;
    scan_state_t scan_st;
    disp_value_t value;

    assign value = '{
        lead_is_sign: lead_is_sign,
        negative:     negative,
        lead:         digit_lead,
        hundreds:     digit_hundreds,
        tens:         digit_tens,
        units:        digit_units
    };

    scan_divider #(
        .CLK_HZ (CLK_HZ),
        .SCAN_HZ(SCAN_HZ)
    ) u_div (
        .clk (clk),
        .rst (rst),
        .tick(scan_tick)
    );

    digit_sequencer u_seq (
        .clk  (clk),
        .rst  (rst),
        .tick (scan_tick),
        .state(scan_st)
    );

    digit_select_decode u_dec (
        .val  (value),
        .st   (scan_st),
        .an_n (an_n),
        .seg_n(seg_n)
    );
endmodule

// File: rtl/disp_checker.sv
module disp_checker
    import disp_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned SCAN_HZ = 250
) (
    input logic       clk,
    input logic       rst,
    input logic       scan_tick,
    input logic [3:0] an_n,
    input logic [6:0] seg_n
);
    localparam int unsigned LIMIT = scan_limit(CLK_HZ, SCAN_HZ);

    logic [31:0] gap;

    always_ff @(posedge clk) begin
        if (rst || scan_tick) gap <= '0;
        else                  gap <= gap + 32'd1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        scan_tick |-> (gap == 32'(LIMIT)));                                 // R1
    AST_TICK_DUE: assert property (@(posedge clk) disable iff (rst)
        (gap == 32'(LIMIT)) |-> scan_tick);                                  // R1
    AST_ONE_ANODE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~an_n));                                                    // R2
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !scan_tick |=> $stable(an_n));                                       // R2
    AST_ROTATE: assert property (@(posedge clk) disable iff (rst)
        (scan_tick && an_n != 4'hF) |=> (an_n == {$past(an_n[2:0]), $past(an_n[3])})); // R3
    AST_FIRST_DIGIT: assert property (@(posedge clk) disable iff (rst)
        (scan_tick && an_n == 4'hF) |=> (an_n == 4'b1110));                  // R4
    AST_DARK_BLANK: assert property (@(posedge clk) disable iff (rst)
        (an_n == 4'hF) |-> (seg_n == 7'h7F));                                // R4
endmodule

bind mux_display_driver disp_checker #(
    .CLK_HZ (CLK_HZ),
    .SCAN_HZ(SCAN_HZ)
) u_disp_chk (
    .clk      (clk),
    .rst      (rst),
    .scan_tick(scan_tick),
    .an_n     (an_n),
    .seg_n    (seg_n)
);

// File: tb/tb_mux_display_driver.sv
module tb_mux_display_driver;
    localparam int CLK_HZ  = 2500;
    localparam int SCAN_HZ = 250;
    localparam int PERIOD  = CLK_HZ / SCAN_HZ;

    logic       clk = 1'b0;
    logic       rst;
    logic       lead_is_sign, negative;
    logic [3:0] digit_lead, digit_hundreds, digit_tens, digit_units;
    logic [3:0] an_n;
    logic [6:0] seg_n;

    always #2 clk = ~clk;

    mux_display_driver #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ)) dut (
        .clk(clk), .rst(rst), .lead_is_sign(lead_is_sign), .negative(negative),
        .digit_lead(digit_lead), .digit_hundreds(digit_hundreds),
        .digit_tens(digit_tens), .digit_units(digit_units),
        .an_n(an_n), .seg_n(seg_n)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Behavioural reference: cycle counter, lit flag, position
    int m_cnt = 0;
    int m_pos = 0;
    bit m_on  = 0;
    bit m_ticked = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_on = 0; m_pos = 0; m_ticked = 0;
        end else if (m_cnt == PERIOD - 1) begin
            m_cnt = 0; m_ticked = 1;
            if (!m_on) m_on = 1;
            else       m_pos = (m_pos + 1) % 4;
        end else begin
            m_cnt++; m_ticked = 0;
        end
    end

    function automatic logic [6:0] exp_digit(input int v);
        logic [6:0] lit;
        case (v)
            0: lit = 7'h3F; 1: lit = 7'h06; 2: lit = 7'h5B; 3: lit = 7'h4F;
            4: lit = 7'h66; 5: lit = 7'h6D; 6: lit = 7'h7D; 7: lit = 7'h07;
            8: lit = 7'h7F; 9: lit = 7'h6F;
            default: lit = 7'h00;
        endcase
        return ~lit;
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [3:0] e_an;
            logic [6:0] e_seg;
            string      an_tag, seg_tag;
            int         code;
            e_an   = m_on ? ~(4'b0001 << m_pos) : 4'hF;
            an_tag = !m_on ? "R4" : (m_ticked ? "R1" : "R3");
            check(an_tag, "an_n", an_n, e_an);
            check("R2", "lit anode count", $countones(~an_n), m_on ? 1 : 0);
            if (!m_on) begin
                e_seg = 7'h7F; seg_tag = "R4";
            end else if (m_pos == 3 && lead_is_sign) begin
                e_seg = negative ? 7'b0111111 : 7'h7F; seg_tag = "R7";
            end else begin
                code = (m_pos == 0) ? digit_units :
                       (m_pos == 1) ? digit_tens :
                       (m_pos == 2) ? digit_hundreds : digit_lead;
                e_seg = exp_digit(code);
                if (code > 9)        seg_tag = "R6";
                else if (m_pos == 3) seg_tag = "R8";
                else                 seg_tag = "R5/R9";
            end
            check(seg_tag, "seg_n", seg_n, e_seg);
        end
    end

    task automatic drive(input bit ls, input bit ng, input int l, input int h, input int t, input int u);
        @(posedge clk); #1;
        lead_is_sign = ls; negative = ng;
        digit_lead = 4'(l); digit_hundreds = 4'(h); digit_tens = 4'(t); digit_units = 4'(u);
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1;
        lead_is_sign = 0; negative = 0;
        digit_lead = 0; digit_hundreds = 0; digit_tens = 0; digit_units = 0;
        run(3); #1 rst = 1'b0;
        // R4: dark until first tick; R9: distinct value per position
        drive(1, 1, 9, 1, 2, 3);
        run(PERIOD * 8 + 3);
        // R7: positive sign blanks, lead value still ignored
        drive(1, 0, 5, 4, 5, 6);
        run(PERIOD * 4 + 1);
        // R8: digit mode with negative held high
        drive(0, 1, 7, 4, 5, 6);
        run(PERIOD * 4 + 2);
        // R5: every decimal code in every position
        for (int v = 0; v < 10; v++) begin
            drive(0, 0, v, v, v, v);
            run(PERIOD * 4);
        end
        // R6: codes 10..15 blank, in both modes
        for (int v = 10; v < 16; v++) begin
            drive(v[0], 1, v, v, v, v);
            run(PERIOD * 4);
        end
        drive(0, 0, 15, 0, 12, 8);
        run(PERIOD * 4);
        // R4/R1: reset in mid-scan restarts dark and re-times the divider
        run(PERIOD / 2);
        @(posedge clk); #1 rst = 1'b1;
        run(2); #1 rst = 1'b0;
        drive(1, 1, 3, 8, 0, 2);
        run(PERIOD * 6);
        summary();
    end
endmodule